// File: doc/BRIEF.md
# GPIO Pad Configuration Register File with Commit Protection

This block holds the pad configuration of one eight-pin general-purpose I/O port. Software reaches it through a simple single-cycle register bus and sets, per pin, the peripheral-function select, the digital enable, one of three drive strengths (2, 4 or 8 mA), pull-up or pull-down, open-drain and slew control. The current per-pin settings go straight to the pad ring.

Some pins are chosen at build time as protected. A protected pin's function select and digital enable can change only where its commit bit is set. The commit register is normally locked. Writing a fixed key to the lock register opens it for exactly one write, and that write closes it again. The three drive registers are mutually exclusive per pin, and so are the two pull registers: setting a bit in one clears that bit in its partners.

The port clock enable comes from outside the block. Any bus access made while that clock is off, or within the first three clock cycles after it turns on, is refused with an error.

Top module: `gpcl_top`

## Requirements
- R1: After reset every configuration output is 0, the lock register reads 1 (locked), and the commit register reads the inverse of the protection mask (0xF0 with the default mask 0x0F).
- R2: An access made while `port_clk_en` is low, or in the cycle it rises or either of the two cycles after, raises `bus_err` in that cycle, returns `bus_rdata` = 0 and changes no register. The access in the fourth cycle completes.
- R3: Writing the key 0xC0DE5A5A to the lock register (address 9) makes it read 0. Writing any other value makes it read 1.
- R4: A write to the commit register (address 10) while locked leaves the commit register unchanged.
- R5: A write to the commit register while unlocked stores the written value and re-locks, so the lock register reads 1 again.
- R6: Writes to function select (address 0) and digital enable (address 1) change a pin only where its commit bit is 1. Other pins keep their value.
- R7: Writing the 2 mA (address 2), 4 mA (address 3) or 8 mA (address 4) drive register stores the value and clears the set bits in the other two drive registers. Clearing bits has no effect on the other two.
- R8: Writing pull-up (address 5) or pull-down (address 6) stores the value and clears the set bits in the other pull register, so clearing both takes two writes.
- R9: The open-drain register (address 7) is changed only by its own writes, never by drive or pull writes.
- R10: The slew output of a pin is the slew register bit (address 8) ANDed with that pin's 8 mA drive bit. The slew register itself reads back as written.
- R11: A read of a configuration register with no error returns its stored value in bits 7:0, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_clk_en | input | 1 | Port clock enabled |
| bus_en | input | 1 | Access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_err | output | 1 | Access refused in this cycle |
| cfg_alt | output | 8 | Peripheral-function select per pin |
| cfg_den | output | 8 | Digital enable per pin |
| cfg_drv2 | output | 8 | 2 mA drive per pin |
| cfg_drv4 | output | 8 | 4 mA drive per pin |
| cfg_drv8 | output | 8 | 8 mA drive per pin |
| cfg_pup | output | 8 | Pull-up per pin |
| cfg_pdn | output | 8 | Pull-down per pin |
| cfg_od | output | 8 | Open-drain per pin |
| cfg_slew | output | 8 | Effective slew control per pin |

## Verification
The assertions assume that the bus inputs are stable across each clock edge and that `port_clk_en` changes only between edges. They also assume that a write's effect is judged against the commit mask held in the same cycle. The bench drives all inputs on the falling edge, holds each access for exactly one cycle, and reads outputs a few nanoseconds later, well before the next rising edge. It turns the port clock on from a known falling edge, so the cycles of the three-cycle refusal window are counted exactly.

// File: rtl/gpcl_pkg.sv
package gpcl_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_ALT  = 4'd0,
    RA_DEN  = 4'd1,
    RA_DRV2 = 4'd2,
    RA_DRV4 = 4'd3,
    RA_DRV8 = 4'd4,
    RA_PUP  = 4'd5,
    RA_PDN  = 4'd6,
    RA_ODE  = 4'd7,
    RA_SLEW = 4'd8,
    RA_LOCK = 4'd9,
    RA_CMT  = 4'd10
  } reg_addr_e;
endpackage

// File: rtl/gpcl_gate.sv
module gpcl_gate #(
  parameter int WARMUP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic port_clk_en,
  output logic ready
);
  localparam int CW = $clog2(WARMUP + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WARMUP);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!port_clk_en)     cnt_q <= '0;
    else if (cnt_q != LIMIT)   cnt_q <= cnt_q + 1'b1;
  end

  assign ready = port_clk_en && (cnt_q == LIMIT);

  a_r2_not_ready_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_clk_en) |-> !ready);
  a_r2_not_ready_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !port_clk_en |-> !ready);
  a_r2_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && port_clk_en) |=> (ready || !port_clk_en));
endmodule

// File: rtl/gpcl_lock.sv
module gpcl_lock #(
  parameter int          PINS = 8,
  parameter int          DW   = 32,
  parameter logic [31:0] KEY  = 32'hC0DE_5A5A,
  parameter logic [7:0]  PROT = 8'h0F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lock_wr,
  input  logic            cmt_wr,
  input  logic [DW-1:0]   wdata,
  output logic            unlocked,
  output logic [PINS-1:0] cmt_mask
);
  localparam logic [PINS-1:0] PROT_M = PINS'(PROT);

  logic unlk_q;
  logic [PINS-1:0] cmt_q;

  function automatic logic key_match(input logic [DW-1:0] v);
    return v == DW'(KEY);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlk_q <= 1'b0;
      cmt_q  <= ~PROT_M;
    end else if (lock_wr) begin
      unlk_q <= key_match(wdata);
    end else if (cmt_wr) begin
      if (unlk_q) cmt_q <= wdata[PINS-1:0];
      unlk_q <= 1'b0;
    end
  end

  assign unlocked = unlk_q;
  assign cmt_mask = cmt_q;

  a_r3_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_wr && key_match(wdata)) |=> unlocked);
  a_r3_bad_key_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_wr && !key_match(wdata)) |=> !unlocked);
  a_r4_locked_commit_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_wr && !lock_wr && !unlocked) |=> $stable(cmt_mask));
  a_r5_commit_relocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_wr && !lock_wr) |=> !unlocked);
endmodule

// File: rtl/gpcl_cfg.sv
module gpcl_cfg #(
  parameter int PINS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [gpcl_pkg::ADDR_W-1:0] addr,
  input  logic [PINS-1:0]             wd,
  input  logic [PINS-1:0]             cmt_mask,
  output logic [PINS-1:0]             alt,
  output logic [PINS-1:0]             den,
  output logic [PINS-1:0]             drv2,
  output logic [PINS-1:0]             drv4,
  output logic [PINS-1:0]             drv8,
  output logic [PINS-1:0]             pup,
  output logic [PINS-1:0]             pdn,
  output logic [PINS-1:0]             ode,
  output logic [PINS-1:0]             slew
);
  import gpcl_pkg::*;

  // Only commit-enabled bits take the new value.
  function automatic logic [PINS-1:0] guarded(input logic [PINS-1:0] old_v,
      input logic [PINS-1:0] new_v, input logic [PINS-1:0] mask);
    return (new_v & mask) | (old_v & ~mask);
  endfunction

  // Bits set in a partner register are cleared here.
  function automatic logic [PINS-1:0] evict(input logic [PINS-1:0] old_v,
      input logic [PINS-1:0] set_v);
    return old_v & ~set_v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alt <= '0; den <= '0; drv2 <= '0; drv4 <= '0; drv8 <= '0;
      pup <= '0; pdn <= '0; ode <= '0; slew <= '0;
    end else if (wr_en) begin
      case (addr)
        RA_ALT:  alt <= guarded(alt, wd, cmt_mask);
        RA_DEN:  den <= guarded(den, wd, cmt_mask);
        RA_DRV2: begin drv2 <= wd; drv4 <= evict(drv4, wd); drv8 <= evict(drv8, wd); end
        RA_DRV4: begin drv4 <= wd; drv2 <= evict(drv2, wd); drv8 <= evict(drv8, wd); end
        RA_DRV8: begin drv8 <= wd; drv2 <= evict(drv2, wd); drv4 <= evict(drv4, wd); end
        RA_PUP:  begin pup <= wd; pdn <= evict(pdn, wd); end
        RA_PDN:  begin pdn <= wd; pup <= evict(pup, wd); end
        RA_ODE:  ode <= wd;
        RA_SLEW: slew <= wd;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    a_r7_one_drive: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({drv2[i], drv4[i], drv8[i]}) <= 1);
    a_r8_one_pull: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pup[i], pdn[i]}));
  end

  a_r6_alt_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((alt ^ $past(alt)) & ~$past(cmt_mask)) == '0);
  a_r6_den_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((den ^ $past(den)) & ~$past(cmt_mask)) == '0);
  a_r9_ode_own_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == RA_ODE) |=> $stable(ode));
endmodule

// File: rtl/gpcl_top.sv
module gpcl_top #(
  parameter int          PINS   = 8,
  parameter int          DW     = 32,
  parameter int          WARMUP = 3,
  parameter logic [31:0] KEY    = 32'hC0DE_5A5A,
  parameter logic [7:0]  PROT   = 8'h0F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            port_clk_en,
  input  logic            bus_en,
  input  logic            bus_wr,
  input  logic [3:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            bus_err,
  output logic [PINS-1:0] cfg_alt,
  output logic [PINS-1:0] cfg_den,
  output logic [PINS-1:0] cfg_drv2,
  output logic [PINS-1:0] cfg_drv4,
  output logic [PINS-1:0] cfg_drv8,
  output logic [PINS-1:0] cfg_pup,
  output logic [PINS-1:0] cfg_pdn,
  output logic [PINS-1:0] cfg_od,
  output logic [PINS-1:0] cfg_slew
);
  import gpcl_pkg::*;

  logic            ready;
  logic            acc_ok;
  logic            wr_ok;
  logic            unlocked;
  logic [PINS-1:0] cmt_mask;
  logic [PINS-1:0] slew_raw;

  gpcl_gate #(.WARMUP(WARMUP)) gate_i (
    .clk(clk), .rst_n(rst_n), .port_clk_en(port_clk_en), .ready(ready)
  );

  assign bus_err = bus_en && !ready;
  assign acc_ok  = bus_en && ready;
  assign wr_ok   = acc_ok && bus_wr;

  gpcl_lock #(.PINS(PINS), .DW(DW), .KEY(KEY), .PROT(PROT)) lock_i (
    .clk(clk), .rst_n(rst_n),
    .lock_wr(wr_ok && bus_addr == RA_LOCK),
    .cmt_wr(wr_ok && bus_addr == RA_CMT),
    .wdata(bus_wdata), .unlocked(unlocked), .cmt_mask(cmt_mask)
  );

  gpcl_cfg #(.PINS(PINS)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .addr(bus_addr),
    .wd(bus_wdata[PINS-1:0]), .cmt_mask(cmt_mask),
    .alt(cfg_alt), .den(cfg_den), .drv2(cfg_drv2), .drv4(cfg_drv4),
    .drv8(cfg_drv8), .pup(cfg_pup), .pdn(cfg_pdn), .ode(cfg_od), .slew(slew_raw)
  );

  assign cfg_slew = slew_raw & cfg_drv8;

  always_comb begin
    bus_rdata = '0;
    if (acc_ok && !bus_wr) begin
      case (bus_addr)
        RA_ALT:  bus_rdata[PINS-1:0] = cfg_alt;
        RA_DEN:  bus_rdata[PINS-1:0] = cfg_den;
        RA_DRV2: bus_rdata[PINS-1:0] = cfg_drv2;
        RA_DRV4: bus_rdata[PINS-1:0] = cfg_drv4;
        RA_DRV8: bus_rdata[PINS-1:0] = cfg_drv8;
        RA_PUP:  bus_rdata[PINS-1:0] = cfg_pup;
        RA_PDN:  bus_rdata[PINS-1:0] = cfg_pdn;
        RA_ODE:  bus_rdata[PINS-1:0] = cfg_od;
        RA_SLEW: bus_rdata[PINS-1:0] = slew_raw;
        RA_LOCK: bus_rdata[0]        = ~unlocked;
        RA_CMT:  bus_rdata[PINS-1:0] = cmt_mask;
        default: ;
      endcase
    end
  end

  a_r2_err_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_wr && bus_err) |=> ($stable(cfg_alt) && $stable(cfg_den) &&
      $stable(cfg_drv8) && $stable(cfg_pup) && $stable(cfg_od) && $stable(cmt_mask)));
  a_r2_err_quiet_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> bus_rdata == '0);
  a_r10_slew_needs_8ma: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_slew & ~cfg_drv8) == '0);
endmodule

// File: tb/gpcl_top_tb_top.sv
`timescale 1ns/1ps
module gpcl_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        port_clk_en = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [7:0]  cfg_alt, cfg_den, cfg_drv2, cfg_drv4, cfg_drv8;
  logic [7:0]  cfg_pup, cfg_pdn, cfg_od, cfg_slew;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] rd;
  logic        er;

  localparam logic [31:0] KEY = 32'hC0DE_5A5A;

  always #10 clk = ~clk;

  gpcl_top dut_i (
    .clk(clk), .rst_n(rst_n), .port_clk_en(port_clk_en),
    .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .cfg_alt(cfg_alt), .cfg_den(cfg_den), .cfg_drv2(cfg_drv2),
    .cfg_drv4(cfg_drv4), .cfg_drv8(cfg_drv8), .cfg_pup(cfg_pup),
    .cfg_pdn(cfg_pdn), .cfg_od(cfg_od), .cfg_slew(cfg_slew)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called on a falling edge; returns on the next falling edge.
  task automatic acc(input logic wr, input logic [3:0] a, input logic [31:0] d,
                     output logic [31:0] r, output logic e);
    bus_en = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #2;
    r = bus_rdata; e = bus_err;
    @(posedge clk);
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    chk("R1 alt", {24'd0, cfg_alt}, 0);
    chk("R1 drv8", {24'd0, cfg_drv8}, 0);
    chk("R1 pup", {24'd0, cfg_pup}, 0);
    chk("R1 od/slew", {16'd0, cfg_od, cfg_slew}, 0);
  endtask

  task automatic t_warmup;
    acc(1'b1, 4'd0, 32'hFF, rd, er);
    chk("R2 err clock off", {31'd0, er}, 1);
    chk("R2 no write clock off", {24'd0, cfg_alt}, 0);
    port_clk_en = 1'b1;
    acc(1'b0, 4'd9, 0, rd, er);
    chk("R2 err cycle0", {31'd0, er}, 1);
    chk("R2 rdata zero", rd, 0);
    acc(1'b1, 4'd0, 32'hFF, rd, er);
    chk("R2 err cycle1", {31'd0, er}, 1);
    acc(1'b1, 4'd1, 32'hFF, rd, er);
    chk("R2 err cycle2", {31'd0, er}, 1);
    chk("R2 no write warmup", {16'd0, cfg_alt, cfg_den}, 0);
    acc(1'b0, 4'd9, 0, rd, er);
    chk("R2 ok cycle3", {31'd0, er}, 0);
    chk("R1 lock reads locked", rd, 1);
    acc(1'b0, 4'd10, 0, rd, er);
    chk("R1 commit reset", rd, 32'hF0);
  endtask

  task automatic t_protect;
    acc(1'b1, 4'd0, 32'hFF, rd, er);
    chk("R6 alt unprotected only", {24'd0, cfg_alt}, 32'hF0);
    acc(1'b1, 4'd1, 32'h5A, rd, er);
    chk("R6 den unprotected only", {24'd0, cfg_den}, 32'h50);
    acc(1'b0, 4'd0, 0, rd, er);
    chk("R11 alt readback", rd, 32'hF0);
  endtask

  task automatic t_lock;
    acc(1'b1, 4'd10, 32'hFF, rd, er);
    acc(1'b0, 4'd10, 0, rd, er);
    chk("R4 locked commit ignored", rd, 32'hF0);
    acc(1'b1, 4'd9, 32'h1234, rd, er);
    acc(1'b0, 4'd9, 0, rd, er);
    chk("R3 bad key stays locked", rd, 1);
    acc(1'b1, 4'd9, KEY, rd, er);
    acc(1'b0, 4'd9, 0, rd, er);
    chk("R3 key unlocks", rd, 0);
    acc(1'b1, 4'd9, 32'h0, rd, er);
    acc(1'b0, 4'd9, 0, rd, er);
    chk("R3 other value relocks", rd, 1);
    acc(1'b1, 4'd9, KEY, rd, er);
    acc(1'b1, 4'd10, 32'hFF, rd, er);
    acc(1'b0, 4'd9, 0, rd, er);
    chk("R5 commit write relocks", rd, 1);
    acc(1'b0, 4'd10, 0, rd, er);
    chk("R5 commit stored", rd, 32'hFF);
    acc(1'b1, 4'd0, 32'h3C, rd, er);
    chk("R6 alt after commit", {24'd0, cfg_alt}, 32'h3C);
    acc(1'b1, 4'd10, 32'h00, rd, er);
    acc(1'b0, 4'd10, 0, rd, er);
    chk("R4 second write ignored", rd, 32'hFF);
  endtask

  task automatic t_drive;
    acc(1'b1, 4'd7, 32'hAA, rd, er);
    acc(1'b1, 4'd2, 32'hFF, rd, er);
    chk("R7 drv2 set", {8'd0, cfg_drv2, cfg_drv4, cfg_drv8}, 32'hFF0000);
    acc(1'b1, 4'd3, 32'h0F, rd, er);
    chk("R7 drv4 evicts drv2", {8'd0, cfg_drv2, cfg_drv4, cfg_drv8}, 32'hF00F00);
    acc(1'b1, 4'd4, 32'h03, rd, er);
    chk("R7 drv8 evicts", {8'd0, cfg_drv2, cfg_drv4, cfg_drv8}, 32'hF00C03);
    acc(1'b1, 4'd2, 32'h00, rd, er);
    chk("R7 clear no coupling", {8'd0, cfg_drv2, cfg_drv4, cfg_drv8}, 32'h000C03);
    chk("R9 od after drive", {24'd0, cfg_od}, 32'hAA);
  endtask

  task automatic t_pull;
    acc(1'b1, 4'd5, 32'hFF, rd, er);
    acc(1'b1, 4'd6, 32'h0F, rd, er);
    chk("R8 pdn evicts pup", {16'd0, cfg_pup, cfg_pdn}, 32'hF00F);
    acc(1'b1, 4'd5, 32'h00, rd, er);
    chk("R8 first clear", {16'd0, cfg_pup, cfg_pdn}, 32'h000F);
    acc(1'b1, 4'd6, 32'h00, rd, er);
    chk("R8 second clear", {16'd0, cfg_pup, cfg_pdn}, 32'h0000);
    chk("R9 od after pull", {24'd0, cfg_od}, 32'hAA);
    acc(1'b0, 4'd7, 0, rd, er);
    chk("R11 od readback", rd, 32'hAA);
  endtask

  task automatic t_slew;
    acc(1'b1, 4'd8, 32'hFF, rd, er);
    chk("R10 slew gated by drv8", {24'd0, cfg_slew}, 32'h03);
    acc(1'b1, 4'd4, 32'h30, rd, er);
    chk("R10 slew follows drv8", {24'd0, cfg_slew}, 32'h30);
    acc(1'b0, 4'd8, 0, rd, er);
    chk("R10 slew reg readback", rd, 32'hFF);
  endtask

  initial begin
    #100000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    t_reset();
    t_warmup();
    t_protect();
    t_lock();
    t_drive();
    t_pull();
    t_slew();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule